// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block holds the status and control-flow state that a small processor core changes when it takes an exception and when it comes back from one. It keeps the current status word (processor mode, IRQ mask and FIQ mask), a saved-status register and a link register for every privileged mode, and the program counter. While nothing is pending, the program counter simply takes the next fetch address offered by the core.

When one or more exception requests are raised, one is chosen by a fixed priority. In a single clock edge the block copies the current status into the saved-status register of the target mode, writes a return address into that mode's link register, switches the mode, sets the interrupt masks and loads the program counter with the exception's vector. A return strobe undoes this. The block copies the current mode's saved status back into the current status word and restarts execution just after the interrupted instruction.

Top module: `trap_unit`

## Requirements
- R1: While reset is asserted and after it is released, before any clock edge with a request, the mode is supervisor (5'b10011), both IRQ and FIQ masks read 1 and the program counter is the vector base (0). Every saved-status register resets to user mode with both masks clear, and every return address resets to 0.
- R2: In a cycle with no accepted request and no return, the program counter takes fetch_pc_i at the next edge and mode and masks stay unchanged.
- R3: Taking an exception sets the mode to the target mode of that kind and the program counter to the vector base plus the vector offset, both at the next edge. The kinds, with target mode and vector offset, are: reset (supervisor, 0x00), undefined (11011, 0x04), supervisor call (10011, 0x08), prefetch abort (10111, 0x0C), data abort (10111, 0x10), IRQ (10010, 0x18) and FIQ (10001, 0x1C). User mode is 10000.
- R4: Taking an exception copies the status word as it was before entry (mode and both masks) into the saved-status register of the target mode.
- R5: The link value stored on entry is the program counter plus 4, or plus 8 for a data abort. On return it is corrected by the exception kind, so that every return resumes at the program counter of entry plus 4.
- R6: Every accepted exception sets the IRQ mask. FIQ and reset also set the FIQ mask. Other kinds leave the FIQ mask as it was.
- R7: Request bit positions are reset 0, undefined 1, supervisor call 2, prefetch abort 3, data abort 4, IRQ 6 and FIQ 7. Bit 5 is unused. When several are raised at once, reset wins, then data abort, FIQ, IRQ, prefetch abort, undefined and supervisor call.
- R8: An IRQ request while the IRQ mask is set, or an FIQ request while the FIQ mask is set, is ignored: the program counter follows fetch_pc_i and mode and masks stay unchanged.
- R9: A return in a privileged mode loads the current status word from that mode's saved-status register at the next edge.
- R10: A return in user mode is ignored (R2 applies). A return in the same cycle as an accepted exception is ignored and the exception is taken.
- R11: Each privileged mode has its own saved-status and link registers. An exception taken inside a handler of a different mode, followed by two returns, comes back first to the handler and then to the original state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req_i | input | 8 | Exception request bits (positions in R7) |
| ret_i | input | 1 | Return-from-exception strobe |
| fetch_pc_i | input | AW | Next fetch address used when no event occurs |
| mode_o | output | 5 | Current processor mode |
| irq_mask_o | output | 1 | IRQ mask bit of the current status |
| fiq_mask_o | output | 1 | FIQ mask bit of the current status |
| pc_o | output | AW | Program counter |

## Verification
A wrong banked register stays hidden until the matching return. At that return it shows up as a wrong mode, a wrong mask or a wrong restart address on the edge after the return strobe. Arbitration or vector errors show on the edge right after the request, as a wrong mode or program counter. The bench therefore mixes nested entries and returns across different modes, so that every bank is written and read back many times, and checks all outputs on every cycle against its own model.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int NKIND = 8;
  localparam int NBANK = 5;
  localparam int BW    = $clog2(NBANK);

  typedef enum logic [2:0] {
    K_RESET = 3'd0, K_UNDEF = 3'd1, K_SVC = 3'd2, K_PABT = 3'd3,
    K_DABT  = 3'd4, K_RSVD  = 3'd5, K_IRQ = 3'd6, K_FIQ  = 3'd7
  } kind_e;

  localparam logic [4:0] M_USR = 5'b10000;
  localparam logic [4:0] M_FIQ = 5'b10001;
  localparam logic [4:0] M_IRQ = 5'b10010;
  localparam logic [4:0] M_SVC = 5'b10011;
  localparam logic [4:0] M_ABT = 5'b10111;
  localparam logic [4:0] M_UND = 5'b11011;

  typedef struct packed {
    logic       i;
    logic       f;
    logic [4:0] mode;
  } psr_t;

  function automatic logic [4:0] kind_mode(kind_e k);
    case (k)
      K_UNDEF:        return M_UND;
      K_PABT, K_DABT: return M_ABT;
      K_IRQ:          return M_IRQ;
      K_FIQ:          return M_FIQ;
      default:        return M_SVC;
    endcase
  endfunction

  function automatic logic is_banked(logic [4:0] m);
    return (m == M_FIQ) || (m == M_IRQ) || (m == M_SVC) ||
           (m == M_ABT) || (m == M_UND);
  endfunction

  function automatic logic [BW-1:0] mode_bank(logic [4:0] m);
    case (m)
      M_FIQ:   return BW'(0);
      M_IRQ:   return BW'(1);
      M_ABT:   return BW'(3);
      M_UND:   return BW'(4);
      default: return BW'(2);
    endcase
  endfunction

  function automatic logic [3:0] link_off(kind_e k);
    return (k == K_DABT) ? 4'd8 : 4'd4;
  endfunction

  function automatic logic [4:0] vec_off(kind_e k);
    return {k, 2'b00};
  endfunction
endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_pkg::*;
(
  input  logic [NKIND-1:0] req,
  input  logic             i_mask,
  input  logic             f_mask,
  output logic             take,
  output kind_e            kind,
  output logic [NKIND-1:0] grant
);
  localparam int NPRIO = 7;
  localparam logic [2:0] PRIO [NPRIO] =
    '{3'd0, 3'd4, 3'd7, 3'd6, 3'd3, 3'd1, 3'd2};

  logic [NKIND-1:0] eligible;

  always_comb begin
    eligible = req;
    eligible[int'(K_IRQ)]  = req[int'(K_IRQ)] & ~i_mask;
    eligible[int'(K_FIQ)]  = req[int'(K_FIQ)] & ~f_mask;
    eligible[int'(K_RSVD)] = 1'b0;
  end

  always_comb begin
    take  = 1'b0;
    kind  = K_RESET;
    grant = '0;
    for (int p = NPRIO - 1; p >= 0; p--) begin
      if (eligible[PRIO[p]]) begin
        take = 1'b1;
        kind = kind_e'(PRIO[p]);
      end
    end
    grant[kind] = take;
  end
endmodule

// File: rtl/trap_bank.sv
module trap_bank
  import trap_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [BW-1:0] wr_idx,
  input  psr_t          wr_psr,
  input  logic [AW-1:0] wr_lr,
  input  logic          wr_deep,
  input  logic [BW-1:0] rd_idx,
  output psr_t          rd_psr,
  output logic [AW-1:0] rd_lr,
  output logic          rd_deep
);
  psr_t          spsr_q [NBANK];
  logic [AW-1:0] lr_q   [NBANK];
  logic          deep_q [NBANK];

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        spsr_q[g] <= '{i: 1'b0, f: 1'b0, mode: M_USR};
        lr_q[g]   <= '0;
        deep_q[g] <= 1'b0;
      end else if (wr_en && (wr_idx == BW'(g))) begin
        spsr_q[g] <= wr_psr;
        lr_q[g]   <= wr_lr;
        deep_q[g] <= wr_deep;
      end
    end
  end

  always_comb begin
    rd_psr  = spsr_q[0];
    rd_lr   = lr_q[0];
    rd_deep = deep_q[0];
    for (int b = 1; b < NBANK; b++) begin
      if (rd_idx == BW'(b)) begin
        rd_psr  = spsr_q[b];
        rd_lr   = lr_q[b];
        rd_deep = deep_q[b];
      end
    end
  end
endmodule

// File: rtl/trap_unit.sv
module trap_unit
  import trap_pkg::*;
#(
  parameter int            AW       = 32,
  parameter logic [AW-1:0] VEC_BASE = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NKIND-1:0] exc_req_i,
  input  logic             ret_i,
  input  logic [AW-1:0]    fetch_pc_i,
  output logic [4:0]       mode_o,
  output logic             irq_mask_o,
  output logic             fiq_mask_o,
  output logic [AW-1:0]    pc_o
);
  psr_t          psr_q;
  logic [AW-1:0] pc_q;

  logic             take_w;
  kind_e            kind_w;
  logic [NKIND-1:0] grant_w;
  logic             ret_fire_w;
  psr_t             entry_psr_w;
  logic [AW-1:0]    link_w;
  logic [AW-1:0]    vector_w;
  psr_t             saved_psr_w;
  logic [AW-1:0]    saved_lr_w;
  logic             saved_deep_w;
  logic [AW-1:0]    resume_w;

  trap_arbiter u_arb (
    .req    (exc_req_i),
    .i_mask (psr_q.i),
    .f_mask (psr_q.f),
    .take   (take_w),
    .kind   (kind_w),
    .grant  (grant_w)
  );

  assign link_w   = pc_q + AW'(link_off(kind_w));
  assign vector_w = VEC_BASE + AW'(vec_off(kind_w));

  trap_bank #(.AW(AW)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (take_w),
    .wr_idx  (mode_bank(kind_mode(kind_w))),
    .wr_psr  (psr_q),
    .wr_lr   (link_w),
    .wr_deep (kind_w == K_DABT),
    .rd_idx  (mode_bank(psr_q.mode)),
    .rd_psr  (saved_psr_w),
    .rd_lr   (saved_lr_w),
    .rd_deep (saved_deep_w)
  );

  assign ret_fire_w = ret_i && !take_w && is_banked(psr_q.mode);
  assign resume_w   = saved_lr_w - (saved_deep_w ? AW'(4) : AW'(0));

  always_comb begin
    entry_psr_w      = psr_q;
    entry_psr_w.mode = kind_mode(kind_w);
    entry_psr_w.i    = 1'b1;
    if (kind_w == K_FIQ || kind_w == K_RESET) entry_psr_w.f = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psr_q <= '{i: 1'b1, f: 1'b1, mode: M_SVC};
      pc_q  <= VEC_BASE;
    end else if (take_w) begin
      psr_q <= entry_psr_w;
      pc_q  <= vector_w;
    end else if (ret_fire_w) begin
      psr_q <= saved_psr_w;
      pc_q  <= resume_w;
    end else begin
      pc_q  <= fetch_pc_i;
    end
  end

  assign mode_o     = psr_q.mode;
  assign irq_mask_o = psr_q.i;
  assign fiq_mask_o = psr_q.f;
  assign pc_o       = pc_q;
endmodule

// File: rtl/trap_unit_chk.sv
module trap_unit_chk
  import trap_pkg::*;
#(
  parameter int            AW       = 32,
  parameter logic [AW-1:0] VEC_BASE = '0
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NKIND-1:0] exc_req_i,
  input logic             ret_i,
  input logic [AW-1:0]    fetch_pc_i,
  input logic [4:0]       mode_o,
  input logic             irq_mask_o,
  input logic             fiq_mask_o,
  input logic [AW-1:0]    pc_o,
  input logic             take_w,
  input kind_e            kind_w,
  input logic [NKIND-1:0] grant_w
);
  a_r2_follow_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_w && !ret_i) |=> (pc_o == $past(fetch_pc_i)) && $stable(mode_o));

  a_r3_entry_mode: assert property (@(posedge clk) disable iff (!rst_n)
    take_w |=> mode_o == kind_mode($past(kind_w)));

  a_r3_entry_vector: assert property (@(posedge clk) disable iff (!rst_n)
    take_w |=> pc_o == VEC_BASE + AW'({$past(kind_w), 2'b00}));

  a_r6_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    take_w |=> irq_mask_o);

  a_r6_fiq_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (take_w && fiq_mask_o) |=> fiq_mask_o);

  a_r7_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_w) && (take_w == (grant_w != '0)));

  a_r8_masked_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask_o && exc_req_i == 8'h40) |-> !take_w);

  a_r8_masked_fiq: assert property (@(posedge clk) disable iff (!rst_n)
    (fiq_mask_o && exc_req_i == 8'h80) |-> !take_w);

  a_r10_user_return: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !take_w && mode_o == M_USR) |=> mode_o == M_USR);
endmodule

bind trap_unit trap_unit_chk #(.AW(AW), .VEC_BASE(VEC_BASE)) u_chk (.*);

// File: tb/trap_unit_bench.sv
module trap_unit_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  exc_req_i = '0;
  logic        ret_i = 1'b0;
  logic [31:0] fetch_pc_i = '0;
  logic [4:0]  mode_o;
  logic        irq_mask_o, fiq_mask_o;
  logic [31:0] pc_o;

  int n_chk = 0;
  int n_bad = 0;

  trap_unit u_trap_unit (
    .clk(clk), .rst_n(rst_n), .exc_req_i(exc_req_i), .ret_i(ret_i),
    .fetch_pc_i(fetch_pc_i), .mode_o(mode_o), .irq_mask_o(irq_mask_o),
    .fiq_mask_o(fiq_mask_o), .pc_o(pc_o)
  );

  always #(CLK_P / 2) clk = ~clk;

  // bench model
  logic [4:0]  m_mode;
  logic        m_i, m_f;
  logic [31:0] m_pc;
  logic [4:0]  s_mode [5];
  logic        s_i [5];
  logic        s_f [5];
  logic [31:0] s_ret [5];

  function automatic int target_mode(int k);
    if (k == 1) return 5'b11011;
    if (k == 3 || k == 4) return 5'b10111;
    if (k == 6) return 5'b10010;
    if (k == 7) return 5'b10001;
    return 5'b10011;
  endfunction

  function automatic int slot(logic [4:0] m);
    case (m)
      5'b10001: return 0;
      5'b10010: return 1;
      5'b10011: return 2;
      5'b10111: return 3;
      5'b11011: return 4;
      default:  return -1;
    endcase
  endfunction

  function automatic int winner(logic [7:0] rq, logic im, logic fm);
    if (rq[0]) return 0;
    if (rq[4]) return 4;
    if (rq[7] && !fm) return 7;
    if (rq[6] && !im) return 6;
    if (rq[3]) return 3;
    if (rq[1]) return 1;
    if (rq[2]) return 2;
    return -1;
  endfunction

  task automatic model_reset();
    m_mode = 5'b10011; m_i = 1'b1; m_f = 1'b1; m_pc = 32'h0;
    for (int b = 0; b < 5; b++) begin
      s_mode[b] = 5'b10000; s_i[b] = 1'b0; s_f[b] = 1'b0; s_ret[b] = 32'h0;
    end
  endtask

  task automatic check(string tag);
    n_chk++;
    if (mode_o !== m_mode || irq_mask_o !== m_i || fiq_mask_o !== m_f || pc_o !== m_pc) begin
      n_bad++;
      $display("FAIL %s: got mode=%b i=%b f=%b pc=%h, expected mode=%b i=%b f=%b pc=%h",
               tag, mode_o, irq_mask_o, fiq_mask_o, pc_o, m_mode, m_i, m_f, m_pc);
    end
  endtask

  // drive one cycle, advance the model, compare after the edge
  task automatic step(logic [7:0] rq, logic rt, logic [31:0] fa, string tag);
    string t;
    int k, b;
    @(negedge clk);
    exc_req_i = rq; ret_i = rt; fetch_pc_i = fa;
    k = winner(rq, m_i, m_f);
    t = tag;
    if (k >= 0) begin
      b = slot(5'(target_mode(k)));
      s_mode[b] = m_mode; s_i[b] = m_i; s_f[b] = m_f;
      s_ret[b] = m_pc + 32'd4;
      m_mode = 5'(target_mode(k));
      m_i = 1'b1;
      if (k == 7 || k == 0) m_f = 1'b1;
      m_pc = 32'(k * 4);
      if (t == "") t = (k == 4) ? "R5" : (k == 6 || k == 7) ? "R6" : "R3";
    end else if (rt && slot(m_mode) >= 0) begin
      b = slot(m_mode);
      m_pc = s_ret[b];
      m_mode = s_mode[b]; m_i = s_i[b]; m_f = s_f[b];
      if (t == "") t = "R9";
    end else begin
      m_pc = fa;
      if (t == "") t = rt ? "R10" : "R2";
    end
    @(posedge clk);
    #1;
    check(t);
  endtask

  initial begin
    #(CLK_P * 190000);
    n_bad++;
    $display("FAIL watchdog: got no finish, expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240917));
    model_reset();
    repeat (3) @(posedge clk);
    #1; check("R1");
    @(negedge clk); rst_n = 1'b1;
    #1; check("R1");

    step(8'h00, 1'b1, 32'h0000_0100, "R9");   // supervisor -> user
    step(8'h00, 1'b0, 32'h0000_0200, "R2");
    step(8'h00, 1'b0, 32'h0000_0204, "R2");
    step(8'h40, 1'b0, 32'h0000_0208, "R6");   // IRQ taken from pc 0x204
    step(8'h40, 1'b0, 32'h0000_0300, "R8");   // masked IRQ
    step(8'h80, 1'b0, 32'h0000_0304, "R6");   // FIQ still open inside IRQ
    step(8'h80, 1'b0, 32'h0000_0400, "R8");   // masked FIQ
    step(8'h00, 1'b1, 32'h0000_0404, "R11");  // back to IRQ handler
    step(8'h02, 1'b0, 32'h0000_0500, "R3");   // undefined inside IRQ
    step(8'h00, 1'b1, 32'h0000_0504, "R11");
    step(8'h00, 1'b1, 32'h0000_0508, "R11");  // back to user, masks clear
    step(8'h00, 1'b0, 32'h0000_0600, "R2");
    step(8'h10, 1'b0, 32'h0000_0604, "R5");   // data abort, link +8
    step(8'h00, 1'b1, 32'h0000_0608, "R5");   // resume at 0x604
    step(8'h08, 1'b0, 32'h0000_0700, "R5");   // prefetch abort, link +4
    step(8'h00, 1'b1, 32'h0000_0704, "R5");
    step(8'hFE, 1'b0, 32'h0000_0800, "R7");   // data abort wins
    step(8'h00, 1'b1, 32'h0000_0804, "R7");
    step(8'hC8, 1'b0, 32'h0000_0900, "R7");   // FIQ wins
    step(8'h00, 1'b1, 32'h0000_0904, "R7");
    step(8'h4A, 1'b0, 32'h0000_0A00, "R7");   // IRQ wins
    step(8'h00, 1'b1, 32'h0000_0A04, "R7");
    step(8'h06, 1'b0, 32'h0000_0B00, "R7");   // undefined over supervisor call
    step(8'h00, 1'b1, 32'h0000_0B04, "R7");
    step(8'h20, 1'b0, 32'h0000_0C00, "R7");   // unused bit
    step(8'h00, 1'b1, 32'h0000_0C04, "R10");  // return in user mode
    step(8'h04, 1'b1, 32'h0000_0D00, "R10");  // entry beats return
    step(8'h00, 1'b1, 32'h0000_0D04, "R4");   // restores user state
    step(8'h01, 1'b0, 32'h0000_0E00, "R3");   // reset request
    step(8'h00, 1'b1, 32'h0000_0E04, "R4");

    for (int n = 0; n < 4000; n++) begin
      logic [7:0] rq;
      int r;
      r = int'($urandom % 20);
      rq = 8'h00;
      if (r < 3) rq = 8'(1 << (1 + $urandom % 7));
      else if (r == 3) rq = 8'($urandom) & 8'hDE;
      else if (r == 4 && ($urandom % 8) == 0) rq = 8'h01;
      step(rq, ($urandom % 3) == 0, $urandom & 32'hFFFF_FFFC, "");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule